// File: doc/BRIEF.md
# Signed Leading-Sign Normalizer

This block takes a two's-complement word and finds how many extra copies of the sign bit sit directly below the most significant bit. It shifts the word left by that amount, so the two top bits of the result always differ unless the input is all zeros or all ones. It returns both the normalized word and the shift amount. It is meant as the operand pre-normalization stage in front of a signed integer divider. The divider later uses the count to undo the scaling.

The block is purely combinational, with no clock, no state and no handshake. One leading-ones detector serves both signs. A non-negative input is complemented before detection, so its leading zeros show up as leading ones. The shift itself always acts on the original input and fills the vacated low positions with zeros.

Top module: `sign_normalizer`

## Requirements
- R1: For an input that is neither all zeros nor all ones, `shift_o` equals the number of consecutive bits directly below bit WIDTH-1 that equal bit WIDTH-1.
- R2: `norm_o` equals `value_i` shifted left by `shift_o`, with zeros entering the vacated low positions for inputs of either sign.
- R3: For an input that is neither all zeros nor all ones, bit WIDTH-1 of `norm_o` equals the input sign bit and bit WIDTH-2 of `norm_o` is its complement.
- R4: An input whose two top bits already differ gives `shift_o` = 0 and `norm_o` = `value_i`.
- R5: An all-zeros input gives `shift_o` = WIDTH-1 (31 by default) and `norm_o` = 0.
- R6: An all-ones input (-1) gives `shift_o` = WIDTH-1 and `norm_o` with only bit WIDTH-1 set (0x80000000 by default).
- R7: Inputs of equal magnitude structure but opposite sign give the same count: +1 and -2 both give a count of 30, with results 0x40000000 and 0x80000000.
- R8: The outputs follow an input change within the same clock period, without any clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| value_i | input | WIDTH | Two's-complement word to normalize |
| norm_o | output | WIDTH | Input shifted left by the redundant sign-bit count |
| shift_o | output | $clog2(WIDTH) | Number of redundant sign bits removed |

## Verification
The bench targets the two saturating inputs, zero and minus one. A design that does not clamp the count would return a wrapped count there, or it would fill -1 with ones instead of giving a lone sign bit. It also drives already-normalized words in both signs, where an off-by-one detector would shift them by one and destroy the sign. Each random word is walked down by arithmetic right shifts, which sweeps every count from 0 to 31 for both signs. A design that filled a negative input's low bits with ones would fail these checks, and so would one that ran detection on the uncomplemented positive value. A final check changes the input mid-period, which catches any hidden storage on the path.

// File: rtl/sign_norm_pkg.sv
package sign_norm_pkg;
    // Default data width of the normalizer.
    localparam int DEF_WIDTH = 32;

    // Detector width rounded up to a power of two, so the halving tree is regular.
    function automatic int pad_width(input int width);
        return 2 ** $clog2(width);
    endfunction
endpackage

// File: rtl/sign_fold.sv
// Folds the sign into the detector input: non-negative words are inverted, so
// redundant sign bits always appear as ones below the top bit.
module sign_fold #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    output logic [WIDTH-2:0] fold_o
);
    always_comb begin
        if (value_i[WIDTH-1]) fold_o = value_i[WIDTH-2:0];
        else                  fold_o = ~value_i[WIDTH-2:0];
    end
endmodule

// File: rtl/lead_ones_tree.sv
// Log-depth leading-ones counter. At each level it tests whether the top chunk
// is all ones; if so it sets that count bit and discards the chunk. A zero pad
// at the bottom makes an all-ones input saturate at IN_W.
module lead_ones_tree
    import sign_norm_pkg::*;
#(
    parameter int IN_W  = 31,
    parameter int CNT_W = 5
) (
    input  logic [IN_W-1:0]  bits_i,
    output logic [CNT_W-1:0] count_o
);
    localparam int PW  = 2 ** CNT_W;
    localparam int PAD = PW - IN_W;

    logic [PW-1:0] lvl [CNT_W+1];

    assign lvl[0] = {bits_i, {PAD{1'b0}}};

    for (genvar k = 0; k < CNT_W; k++) begin : g_level
        localparam int BIT   = CNT_W - 1 - k;
        localparam int CHUNK = 2 ** BIT;
        logic hit;
        assign hit           = &lvl[k][PW-1 -: CHUNK];
        assign count_o[BIT]  = hit;
        assign lvl[k+1]      = hit ? (lvl[k] << CHUNK) : lvl[k];
    end
endmodule

// File: rtl/zero_fill_shifter.sv
// Logarithmic left shifter; each stage shifts by a power of two, zero fill.
module zero_fill_shifter #(
    parameter int WIDTH = 32,
    parameter int CNT_W = 5
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [CNT_W-1:0] amt_i,
    output logic [WIDTH-1:0] data_o
);
    logic [WIDTH-1:0] stg [CNT_W+1];

    assign stg[0] = data_i;

    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        assign stg[s+1] = amt_i[s] ? (stg[s] << (2 ** s)) : stg[s];
    end

    assign data_o = stg[CNT_W];
endmodule

// File: rtl/sign_normalizer.sv
module sign_normalizer
    import sign_norm_pkg::*;
#(
    parameter  int WIDTH = DEF_WIDTH,
    localparam int CNT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value_i,
    output logic [WIDTH-1:0] norm_o,
    output logic [CNT_W-1:0] shift_o
);
    logic [WIDTH-2:0] fold;

    sign_fold #(.WIDTH(WIDTH)) i_fold (
        .value_i (value_i),
        .fold_o  (fold)
    );

    lead_ones_tree #(.IN_W(WIDTH-1), .CNT_W(CNT_W)) i_detect (
        .bits_i  (fold),
        .count_o (shift_o)
    );

    zero_fill_shifter #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_shift (
        .data_i  (value_i),
        .amt_i   (shift_o),
        .data_o  (norm_o)
    );

    // Checks relating the input to the outputs of separate submodules.
    logic             sat;
    logic [WIDTH-1:0] keep_mask;
    always_comb begin
        sat       = (value_i == '0) || (value_i == '1);
        keep_mask = {WIDTH{1'b1}} << shift_o;

        p_sign_kept_r3: assert (sat || (norm_o[WIDTH-1] == value_i[WIDTH-1]
                                        && norm_o[WIDTH-2] != value_i[WIDTH-1]))
            else $error("normalized top bits do not carry the sign");

        p_low_zero_fill_r2: assert ((norm_o & ~keep_mask) == '0)
            else $error("vacated low bits not zero");

        p_no_shift_r4: assert (!(value_i[WIDTH-1] != value_i[WIDTH-2])
                               || (shift_o == '0 && norm_o == value_i))
            else $error("already normalized input was shifted");

        p_zero_sat_r5: assert (value_i != '0
                               || (norm_o == '0 && int'(shift_o) == WIDTH-1))
            else $error("zero input not saturated");

        p_ones_sat_r6: assert (value_i != '1
                               || (norm_o == {1'b1, {(WIDTH-1){1'b0}}}
                                   && int'(shift_o) == WIDTH-1))
            else $error("minus one input not saturated");
    end
endmodule

// File: tb/test_sign_normalizer.sv
module test_sign_normalizer;
    localparam int W  = 32;
    localparam int CW = 5;
    localparam int NV = 12;

    // Vector table: input, expected word, expected count.
    localparam logic [W-1:0] V_IN [NV] = '{
        32'h40000000, 32'h80000000, 32'h00000001, 32'hFFFFFFFE,
        32'h00000000, 32'hFFFFFFFF, 32'h12345678, 32'hF0000000,
        32'hC0000000, 32'h00FF0000, 32'hFFFF8001, 32'h3FFFFFFF };
    localparam logic [W-1:0] V_OUT [NV] = '{
        32'h40000000, 32'h80000000, 32'h40000000, 32'h80000000,
        32'h00000000, 32'h80000000, 32'h48D159E0, 32'h80000000,
        32'h80000000, 32'h7F800000, 32'h80010000, 32'h7FFFFFFE };
    localparam int V_CNT [NV] = '{0, 0, 30, 30, 31, 31, 2, 3, 1, 7, 16, 1};
    // Requirement each row targets (index into a tag list below).
    localparam int V_REQ [NV] = '{4, 4, 7, 7, 5, 6, 1, 1, 1, 1, 2, 3};

    logic clk = 1'b0;
    logic [W-1:0]  value;
    logic [W-1:0]  norm;
    logic [CW-1:0] shift;
    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk; // 50 MHz

    sign_normalizer #(.WIDTH(W)) i_sign_normalizer (
        .value_i (value),
        .norm_o  (norm),
        .shift_o (shift)
    );

    function automatic string req_tag(input int n);
        case (n)
            1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
            5: return "R5"; 6: return "R6"; 7: return "R7"; default: return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s value=%h actual=%h expected=%h", req, value, act, exp);
        end
    endtask

    // Independent reference: count matching bits below the MSB one by one.
    function automatic int ref_count(input logic [W-1:0] v);
        int c = 0;
        for (int i = W - 2; i >= 0; i--) begin
            if (v[i] != v[W-1]) break;
            c++;
        end
        return c;
    endfunction

    initial begin
        value = '0;
        @(negedge clk);
        // Reset-state equivalent: zero input at start (R5).
        check("R5", {27'b0, shift}, 32'd31);
        check("R5", norm, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(posedge clk); value = V_IN[i];
            @(negedge clk);
            check(req_tag(V_REQ[i]), {27'b0, shift}, V_CNT[i]);
            check("R2", norm, V_OUT[i]);
            if (value != '0 && value != '1)
                check("R3", {30'b0, norm[W-1], norm[W-2]},
                      {30'b0, value[W-1], ~value[W-1]});
        end

        // Random words walked down by arithmetic shifts: counts 0..31 (R1, R2).
        for (int r = 0; r < 40; r++) begin
            @(posedge clk); value = $urandom;
            value[W-1] = r[0];
            value[W-2] = ~r[0];
            for (int s = 0; s < W; s++) begin
                @(negedge clk);
                check("R1", {27'b0, shift}, ref_count(value));
                check("R2", norm, value << ref_count(value));
                @(posedge clk); value = $signed(value) >>> 1;
            end
        end

        // Same-period response (R8): change mid-period, sample before next edge.
        @(negedge clk);
        #3 value = 32'h00000001;
        #2 check("R8", {27'b0, shift}, 32'd30);
        check("R8", norm, 32'h40000000);
        #2 value = 32'hFFFFFFFF;
        #2 check("R8", norm, 32'h80000000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule